// File: doc/BRIEF.md
# Pixel Matrix Readout Sequencer

This block drives the digital control strobes of a square active-pixel array that is read one pixel per clock. After a start pulse it walks the rows in ascending order. For each row it first turns on that row's select and source-follower bias, waits a fixed lead time so the shared bias node can settle, then turns on pixel power and steps a one-hot column select across every column, one per clock. A line-steering output follows the column index so that odd and even columns alternate between two readout lines on successive cycles.

Two reset disciplines are offered. In frame mode the sequencer first waits a programmable integration count, reads every row, and then resets the whole matrix at once. In shutter mode each row is reset immediately after its last column is read, which gives every row the same integration time between its reset and its next read. A single-cycle done flag closes each frame. All control strobes are active low. The nominal pixel clock is 10 MHz.

Top module: `pixel_scan_ctrl`

## Requirements
- R1: Out of reset and while idle, every bit of row_sel_n, row_rst_n, sf_pwr_n, pix_pwr_n and col_sel_n is 1, line_sel is 0 and frame_done is 0.
- R2: For each row r, the cycle after the frame's setup begins, bit r of row_sel_n and sf_pwr_n go low for SF_LEAD cycles while pix_pwr_n and col_sel_n stay all ones; pixel power of that row then turns on together with the first column and stays on until the row's last column.
- R3: During a row's read phase, col_sel_n has exactly bit c low in the c-th read cycle, for c = 0 to COLS-1 in order, one column per clock, and at most one row and one column are selected at any time.
- R4: line_sel equals bit 0 of the column index being read (1 for odd-numbered columns, counting from 0, which use the first readout line; 0 for even ones), so it toggles every read cycle, and it is 0 outside read cycles.
- R5: In frame mode (shutter_mode = 0) a start sampled high in idle is followed by integ_len cycles with all strobes inactive before row 0 is powered; integ_len = 0 gives no wait.
- R6: In frame mode no row reset occurs during readout; after the last column of the last row, all bits of row_rst_n go low together for RST_LEN cycles with all power and selects off.
- R7: In shutter mode (shutter_mode = 1) row 0 is powered the cycle after start with no integration wait, and after each row's last column bit r of row_rst_n alone is low for RST_LEN cycles while every power enable and select is off.
- R8: frame_done is high for exactly one cycle, right after the final reset of the frame ends, and the block is idle on the next cycle.
- R9: A start pulse while a frame is in progress has no effect: the frame's strobe sequence and its length are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a frame when idle |
| shutter_mode | input | 1 | 0 = frame mode, 1 = shutter mode; sampled with start |
| integ_len | input | INT_W | Integration wait in cycles for frame mode; sampled with start |
| row_sel_n | output | ROWS | One-hot row select, active low |
| row_rst_n | output | ROWS | Row reset strobes, active low |
| sf_pwr_n | output | ROWS | Source-follower bias enable per row, active low |
| pix_pwr_n | output | ROWS | Pixel power enable per row, active low |
| col_sel_n | output | COLS | One-hot column select, active low |
| line_sel | output | 1 | 1 = odd-column readout line, 0 = even-column line |
| frame_done | output | 1 | One-cycle pulse at frame end |

## Verification
The bench builds the block with 4 rows, 6 columns, a 3-cycle bias lead, a 2-cycle reset and an 8-bit integration count, so every row transition, the last-row-to-reset handover and the done pulse occur within a few dozen cycles and every cycle of a frame can be compared against an expected strobe pattern. With an even column count the line toggle also crosses row boundaries, and frame mode is run with a nonzero and a zero integration count. Start pulses are injected during the integration wait, the bias lead and the read phase to show that a running frame keeps its exact schedule.

// File: rtl/pixscan_pkg.sv
// Shared types of the pixel readout sequencer.
package pixscan_pkg;

    // Sequencer phase. Order carries no meaning.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,  // waiting for start
        PH_INTEG = 3'd1,  // frame mode integration wait
        PH_SFON  = 3'd2,  // row selected, source-follower bias settling
        PH_READ  = 3'd3,  // pixel powered, columns stepping
        PH_RROW  = 3'd4,  // shutter mode reset of the current row
        PH_RALL  = 3'd5,  // frame mode reset of the whole matrix
        PH_DONE  = 3'd6   // one-cycle end of frame
    } scan_phase_t;

endpackage

// File: rtl/pixscan_sel_dec.sv
// Index to active-low one-hot strobe decoder.
// Drives bit idx low when en is high, drives every bit low when all_on is high.
// Assumes idx < N whenever en is high.
module pixscan_sel_dec #(
    parameter int N = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          en,
    input  logic          all_on,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  sel_n
);

    // One comparator per strobe line.
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign sel_n[i] = ~((en && (idx == IW'(i))) || all_on);
    end

endmodule

// File: rtl/pixscan_fsm.sv
// Phase sequencer of the pixel readout.
// Walks integration wait, per-row bias lead, column read and the reset of the
// selected discipline; returns the phase with the current row and column.
// Assumes 1 <= SF_LEAD and 1 <= RST_LEN, both below 2**INT_W.
module pixscan_fsm
    import pixscan_pkg::*;
#(
    parameter int ROWS    = 32,
    parameter int COLS    = 32,
    parameter int SF_LEAD = 4,
    parameter int RST_LEN = 2,
    parameter int INT_W   = 16,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             shutter_mode,
    input  logic [INT_W-1:0] integ_len,
    output scan_phase_t      phase,
    output logic [RW-1:0]    row_idx,
    output logic [CW-1:0]    col_idx
);

    localparam logic [INT_W-1:0] SF_LOAD  = INT_W'(SF_LEAD - 1);
    localparam logic [INT_W-1:0] RST_LOAD = INT_W'(RST_LEN - 1);
    localparam logic [RW-1:0]    ROW_LAST = RW'(ROWS - 1);
    localparam logic [CW-1:0]    COL_LAST = CW'(COLS - 1);

    scan_phase_t      phase_q;
    logic [INT_W-1:0] tmr_q;
    logic [RW-1:0]    row_q;
    logic [CW-1:0]    col_q;
    logic             shut_q;

    // Phase transitions, dwell timer and row/column counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            tmr_q   <= '0;
            row_q   <= '0;
            col_q   <= '0;
            shut_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    row_q <= '0;
                    col_q <= '0;
                    if (start) begin
                        shut_q <= shutter_mode;
                        if (!shutter_mode && (integ_len != '0)) begin
                            phase_q <= PH_INTEG;
                            tmr_q   <= integ_len - 1'b1;
                        end else begin
                            phase_q <= PH_SFON;
                            tmr_q   <= SF_LOAD;
                        end
                    end
                end
                PH_INTEG: begin
                    if (tmr_q == '0) begin
                        phase_q <= PH_SFON;
                        tmr_q   <= SF_LOAD;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                PH_SFON: begin
                    if (tmr_q == '0) begin
                        phase_q <= PH_READ;
                        col_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                PH_READ: begin
                    if (col_q == COL_LAST) begin
                        col_q <= '0;
                        if (shut_q) begin
                            phase_q <= PH_RROW;
                            tmr_q   <= RST_LOAD;
                        end else if (row_q == ROW_LAST) begin
                            phase_q <= PH_RALL;
                            tmr_q   <= RST_LOAD;
                        end else begin
                            phase_q <= PH_SFON;
                            tmr_q   <= SF_LOAD;
                            row_q   <= row_q + 1'b1;
                        end
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                PH_RROW: begin
                    if (tmr_q == '0) begin
                        if (row_q == ROW_LAST) begin
                            phase_q <= PH_DONE;
                        end else begin
                            phase_q <= PH_SFON;
                            tmr_q   <= SF_LOAD;
                            row_q   <= row_q + 1'b1;
                        end
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                PH_RALL: begin
                    if (tmr_q == '0) begin
                        phase_q <= PH_DONE;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    assign phase   = phase_q;
    assign row_idx = row_q;
    assign col_idx = col_q;

endmodule

// File: rtl/pixel_scan_ctrl.sv
// Readout sequencer top for a ROWS x COLS active-pixel array.
// Turns the sequencer phase into active-low row and column strobes, the
// odd/even line steering bit and the end-of-frame pulse.
// Assumes start, shutter_mode and integ_len are synchronous to clk.
module pixel_scan_ctrl
    import pixscan_pkg::*;
#(
    parameter int ROWS    = 32,
    parameter int COLS    = 32,
    parameter int SF_LEAD = 4,
    parameter int RST_LEN = 2,
    parameter int INT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             shutter_mode,
    input  logic [INT_W-1:0] integ_len,
    output logic [ROWS-1:0]  row_sel_n,
    output logic [ROWS-1:0]  row_rst_n,
    output logic [ROWS-1:0]  sf_pwr_n,
    output logic [ROWS-1:0]  pix_pwr_n,
    output logic [COLS-1:0]  col_sel_n,
    output logic             line_sel,
    output logic             frame_done
);

    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

    scan_phase_t   phase;
    logic [RW-1:0] row_idx;
    logic [CW-1:0] col_idx;
    logic          row_on;
    logic          reading;

    pixscan_fsm #(
        .ROWS(ROWS), .COLS(COLS), .SF_LEAD(SF_LEAD),
        .RST_LEN(RST_LEN), .INT_W(INT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .shutter_mode(shutter_mode), .integ_len(integ_len),
        .phase(phase), .row_idx(row_idx), .col_idx(col_idx)
    );

    // Phase-derived enables for the strobe decoders.
    always_comb begin
        reading = (phase == PH_READ);
        row_on  = (phase == PH_SFON) || reading;
    end

    pixscan_sel_dec #(.N(ROWS)) u_row_sel (
        .en(row_on), .all_on(1'b0), .idx(row_idx), .sel_n(row_sel_n));

    pixscan_sel_dec #(.N(ROWS)) u_sf_pwr (
        .en(row_on), .all_on(1'b0), .idx(row_idx), .sel_n(sf_pwr_n));

    pixscan_sel_dec #(.N(ROWS)) u_pix_pwr (
        .en(reading), .all_on(1'b0), .idx(row_idx), .sel_n(pix_pwr_n));

    pixscan_sel_dec #(.N(ROWS)) u_row_rst (
        .en(phase == PH_RROW), .all_on(phase == PH_RALL),
        .idx(row_idx), .sel_n(row_rst_n));

    pixscan_sel_dec #(.N(COLS)) u_col_sel (
        .en(reading), .all_on(1'b0), .idx(col_idx), .sel_n(col_sel_n));

    // Line steering follows the parity of the column being read.
    assign line_sel   = reading && col_idx[0];
    assign frame_done = (phase == PH_DONE);

endmodule

// File: rtl/pixscan_chk.sv
// Temporal checks on the sequencer ports; bound to every pixel_scan_ctrl.
module pixscan_chk #(
    parameter int ROWS = 32,
    parameter int COLS = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ROWS-1:0] row_sel_n,
    input logic [ROWS-1:0] row_rst_n,
    input logic [ROWS-1:0] sf_pwr_n,
    input logic [ROWS-1:0] pix_pwr_n,
    input logic [COLS-1:0] col_sel_n,
    input logic            line_sel,
    input logic            frame_done
);

    // R3
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~row_sel_n));

    // R3
    col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~col_sel_n));

    // R3
    col_needs_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_sel_n != '1) |-> (row_sel_n != '1));

    // R2
    pix_under_sf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pix_pwr_n & sf_pwr_n) == '0));

    // R2
    sf_leads_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pix_pwr_n != '1) && $past(pix_pwr_n == '1)) |-> $past(sf_pwr_n != '1));

    // R4
    line_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((col_sel_n != '1) && $past(col_sel_n != '1)) |-> (line_sel != $past(line_sel)));

    // R6
    rst_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_rst_n != '1) |-> ((sf_pwr_n == '1) && (pix_pwr_n == '1) && (row_sel_n == '1)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R8
    done_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(row_rst_n != '1));

endmodule

bind pixel_scan_ctrl pixscan_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .row_sel_n(row_sel_n), .row_rst_n(row_rst_n),
    .sf_pwr_n(sf_pwr_n), .pix_pwr_n(pix_pwr_n), .col_sel_n(col_sel_n),
    .line_sel(line_sel), .frame_done(frame_done));

// File: tb/tb_pixel_scan_ctrl.sv
// Directed bench: every cycle of each frame is compared against a strobe
// pattern built from the requirements.
module tb_pixel_scan_ctrl;

    localparam int ROWS = 4;
    localparam int COLS = 6;
    localparam int SFL  = 3;
    localparam int RSTL = 2;
    localparam int IW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            shutter_mode = 1'b0;
    logic [IW-1:0]   integ_len = '0;
    logic [ROWS-1:0] row_sel_n, row_rst_n, sf_pwr_n, pix_pwr_n;
    logic [COLS-1:0] col_sel_n;
    logic            line_sel, frame_done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int poke_at = -1;
    bit finished = 1'b0;

    pixel_scan_ctrl #(.ROWS(ROWS), .COLS(COLS), .SF_LEAD(SFL),
                      .RST_LEN(RSTL), .INT_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .shutter_mode(shutter_mode),
        .integ_len(integ_len), .row_sel_n(row_sel_n), .row_rst_n(row_rst_n),
        .sf_pwr_n(sf_pwr_n), .pix_pwr_n(pix_pwr_n), .col_sel_n(col_sel_n),
        .line_sel(line_sel), .frame_done(frame_done));

    always #5 clk = ~clk;

    // Active-low one-hot for index i; negative index means none.
    function automatic logic [ROWS-1:0] rmask(int i);
        return (i < 0) ? '1 : ~(ROWS'(1) << i);
    endfunction

    function automatic logic [COLS-1:0] cmask(int i);
        return (i < 0) ? '1 : ~(COLS'(1) << i);
    endfunction

    // Compare all outputs at the falling edge, optionally poke start, advance.
    task automatic chk(string req, logic [ROWS-1:0] e_sel, logic [ROWS-1:0] e_rst,
                       logic [ROWS-1:0] e_sf, logic [ROWS-1:0] e_pix,
                       logic [COLS-1:0] e_col, logic e_line, logic e_done);
        n_chk++;
        if (row_sel_n !== e_sel || row_rst_n !== e_rst || sf_pwr_n !== e_sf ||
            pix_pwr_n !== e_pix || col_sel_n !== e_col || line_sel !== e_line ||
            frame_done !== e_done) begin
            n_fail++;
            $display("FAIL %s cyc %0d: got sel=%b rst=%b sf=%b pix=%b col=%b line=%b done=%b exp sel=%b rst=%b sf=%b pix=%b col=%b line=%b done=%b",
                     req, cyc, row_sel_n, row_rst_n, sf_pwr_n, pix_pwr_n, col_sel_n,
                     line_sel, frame_done, e_sel, e_rst, e_sf, e_pix, e_col, e_line, e_done);
        end
        start = (cyc == poke_at);
        cyc++;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic chk_idle(string req);
        chk(req, '1, '1, '1, '1, '1, 1'b0, 1'b0);
    endtask

    // Run one frame and check every cycle; pk = cycle for an extra start (-1 none).
    task automatic run_frame(bit shut, int len, int pk, string tag);
        shutter_mode = shut;
        integ_len = IW'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        poke_at = pk;
        if (!shut) begin
            for (int k = 0; k < len; k++) chk({"R5 ", tag}, '1, '1, '1, '1, '1, 1'b0, 1'b0);
        end
        for (int r = 0; r < ROWS; r++) begin
            for (int k = 0; k < SFL; k++)
                chk({"R2 ", tag}, rmask(r), '1, rmask(r), '1, '1, 1'b0, 1'b0);
            for (int c = 0; c < COLS; c++)
                chk({"R3 R4 ", tag}, rmask(r), '1, rmask(r), rmask(r), cmask(c),
                    1'(c % 2), 1'b0);
            if (shut) begin
                for (int k = 0; k < RSTL; k++)
                    chk({"R7 ", tag}, '1, rmask(r), '1, '1, '1, 1'b0, 1'b0);
            end
        end
        if (!shut) begin
            for (int k = 0; k < RSTL; k++)
                chk({"R6 ", tag}, '1, '0, '1, '1, '1, 1'b0, 1'b0);
        end
        chk({"R8 ", tag}, '1, '1, '1, '1, '1, 1'b0, 1'b1);
        poke_at = -1;
        chk_idle({"R8 R1 ", tag});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk_idle("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 idle");
    endtask

    task automatic t_frame();
        run_frame(1'b0, 5, -1, "frame L=5");
    endtask

    task automatic t_frame_zero();
        run_frame(1'b0, 0, -1, "frame L=0");
    endtask

    task automatic t_shutter();
        run_frame(1'b1, 9, -1, "shutter");
    endtask

    task automatic t_busy_start();
        run_frame(1'b0, 4, 2, "R9 start in integ");
        run_frame(1'b0, 0, 1, "R9 start in lead");
        run_frame(1'b1, 0, 8, "R9 start in read");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_frame();
        t_frame_zero();
        t_shutter();
        t_busy_start();
        repeat (3) chk_idle("R1 after");
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule